// File: doc/BRIEF.md
# Reaction Time Tester Controller

This block measures how quickly a person answers a light. Pressing the request button arms the tester. After a long fixed wait the stimulus light turns on, and a four-digit decimal counter then advances once per hundredth of a second. Pressing the stop button turns the light off and freezes the count, so the digits show the reaction time. A reset button returns the block to idle at any time.

All three buttons are active-low and are inverted at the input. Every register runs on the single system clock. The slow rates come from enables: a long delay counter produces the start event, and a reloading down-counter produces a one-cycle tick each timebase period. The timebase is forced to a known phase when the light turns on, so the first count falls exactly one period after the stimulus. When the count reaches 9999 it stops there and raises a saturation output.

Top module: `reaction_timer`

## Requirements
- R1: The buttons are active-low. The reset button clears the run state, the light and all digits on the next clock edge. It overrides request: pressing reset and request together starts nothing.
- R2: When stop is seen at a clock edge, the light is 0 after that edge and the digits keep their value until the next request.
- R3: A request sets a run state that persists after the button is released. The light rises 2^(DELAY_W-1)+1 clock edges after the edge that registers the request.
- R4: The light stays on until reset or stop is seen.
- R5: The count advances every TICK_PERIOD clocks while the light is on. The first advance comes exactly TICK_PERIOD edges after the edge at which the light rises, whatever the prior timebase phase was.
- R6: The digits are packed BCD with digit 0 (least significant) in bits [3:0]. Each digit counts 0 to 9, then wraps to 0 and carries into the next digit.
- R7: A request clears all digits and the saturation output on the next edge.
- R8: When the count reaches 9999 it holds there while the light stays on, and the saturation output reads 1.
- R9: While the asynchronous reset rst_n is low, and immediately after it is released, the light, the digits and the saturation output are 0.
- R10: A stop seen before the light turns on cancels the test, and the light never turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_reset_n | input | 1 | Reset pushbutton, low when pressed |
| btn_request_n | input | 1 | Arm pushbutton, low when pressed |
| btn_stop_n | input | 1 | Stop pushbutton, low when pressed |
| light_o | output | 1 | Stimulus light, high when on |
| digits_o | output | 4*NUM_DIGITS | Packed BCD elapsed count, digit 0 in bits [3:0] |
| sat_o | output | 1 | High while the count holds at all nines |

## Verification
If the delay counter or the run state is wrong, the light rises on the wrong edge. A check on the exact rise cycle exposes this about 2^(DELAY_W-1) cycles after the request. A timebase phase that is not realigned shows up within one period of the rise, as a first advance that comes early or late. A broken carry between digits stays hidden until the 9-to-10, 99-to-100 and 999-to-1000 boundaries, so the count is sampled on the exact edges around those points and at 9999. The freeze after stop and the cancellation by reset are checked by holding the clock running and watching that the light and the digits stay put.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef logic [3:0] bcd_digit_t;
  localparam bcd_digit_t BCD_TOP = 4'd9;
endpackage

// File: rtl/rt_hold_flag.sv
module rt_hold_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_nxt;

  always_comb begin
    if (clr_i) q_nxt = 1'b0;
    else       q_nxt = q_o | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end

  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/rt_delay.sv
module rt_delay #(
  parameter int DELAY_W = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic start_o
);
  logic [DELAY_W-1:0] cnt_q, cnt_d;
  logic               cnt_we;

  always_comb begin
    cnt_we = clr_i | en_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign start_o = cnt_q[DELAY_W-1];
endmodule

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
  parameter int TICK_PERIOD = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_i,
  input  logic active_i,
  output logic tick_o
);
  localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(TICK_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    if (align_i || (active_i && at_zero)) cnt_d = RELOAD;
    else                                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = active_i & at_zero;
endmodule

// File: rtl/rt_bcd_chain.sv
module rt_bcd_chain
  import rt_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    en_i,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic                    sat_o
);
  logic [NUM_DIGITS:0]   low_nines;
  logic [NUM_DIGITS-1:0] is_nine;

  assign low_nines[0] = 1'b1;
  assign sat_o        = low_nines[NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    bcd_digit_t dig_q, dig_d;
    logic       step;

    always_comb begin
      is_nine[g]     = (dig_q == BCD_TOP);
      low_nines[g+1] = low_nines[g] & is_nine[g];
      step           = en_i & ~sat_o & low_nines[g];
      if (clr_i)          dig_d = '0;
      else if (is_nine[g]) dig_d = '0;
      else                dig_d = dig_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              dig_q <= '0;
      else if (clr_i || step)  dig_q <= dig_d;
    end

    assign digits_o[4*g +: 4] = dig_q;

    a_r6_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      dig_q <= BCD_TOP);
  end

  a_r7_clear_digits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (digits_o == '0));
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !clr_i) |=> (sat_o && $stable(digits_o)));
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer #(
  parameter int DELAY_W     = 28,
  parameter int TICK_PERIOD = 500000,
  parameter int NUM_DIGITS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    btn_reset_n,
  input  logic                    btn_request_n,
  input  logic                    btn_stop_n,
  output logic                    light_o,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic                    sat_o
);
  logic do_reset, do_request, do_stop;
  logic halt, count_clr;
  logic armed, active, start_w, align, tick, bcd_en;

  always_comb begin
    do_reset   = ~btn_reset_n;
    do_request = ~btn_request_n;
    do_stop    = ~btn_stop_n;
    halt       = do_reset | do_stop;
    count_clr  = do_reset | do_request;
    align      = start_w & ~active & ~halt;
    bcd_en     = tick;
  end

  rt_hold_flag u_run (
    .clk(clk), .rst_n(rst_n), .set_i(do_request), .clr_i(halt), .q_o(armed)
  );

  rt_delay #(.DELAY_W(DELAY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr_i(halt), .en_i(armed), .start_o(start_w)
  );

  rt_hold_flag u_active (
    .clk(clk), .rst_n(rst_n), .set_i(start_w), .clr_i(halt), .q_o(active)
  );

  rt_tick_gen #(.TICK_PERIOD(TICK_PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .align_i(align), .active_i(active), .tick_o(tick)
  );

  rt_bcd_chain #(.NUM_DIGITS(NUM_DIGITS)) u_bcd (
    .clk(clk), .rst_n(rst_n), .clr_i(count_clr), .en_i(bcd_en),
    .digits_o(digits_o), .sat_o(sat_o)
  );

  assign light_o = active;

  a_r2_stop_kills_light: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !light_o);
  a_r3_light_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(light_o) |-> $past(start_w));
  a_r5_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(light_o) |-> !bcd_en);
  a_r1_reset_blocks_run: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> !armed);
endmodule

// File: tb/tb_reaction_timer.sv
module tb_reaction_timer;
  localparam int DW = 4;
  localparam int TP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_rst_n = 1'b1, b_req_n = 1'b1, b_stop_n = 1'b1;
  logic light;
  logic [15:0] digits;
  logic sat;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    string       tag;
    logic        light;
    logic [15:0] dig;
    logic        sat;
  } exp_t;
  exp_t sb[$];

  reaction_timer #(.DELAY_W(DW), .TICK_PERIOD(TP), .NUM_DIGITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .btn_reset_n(b_rst_n), .btn_request_n(b_req_n),
    .btn_stop_n(b_stop_n), .light_o(light), .digits_o(digits), .sat_o(sat)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] to_bcd(int n);
    return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  task automatic expect_at(int at, string tag, bit l, int n, bit s);
    exp_t e;
    e.at = at; e.tag = tag; e.light = l; e.dig = to_bcd(n); e.sat = s;
    sb.push_back(e);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic press(int which);
    if (which == 0) b_rst_n = 1'b0;
    if (which == 1) b_req_n = 1'b0;
    if (which == 2) b_stop_n = 1'b0;
    @(negedge clk);
    b_rst_n = 1'b1; b_req_n = 1'b1; b_stop_n = 1'b1;
  endtask

  // monitor: compare queued expectations at their cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      n_cmp++;
      if (light !== sb[0].light || digits !== sb[0].dig || sat !== sb[0].sat) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual light=%b dig=%h sat=%b expected light=%b dig=%h sat=%b",
                 sb[0].tag, cyc, light, digits, sat, sb[0].light, sb[0].dig, sb[0].sat);
      end
      void'(sb.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_cmp++;
    if (light !== 1'b0 || digits !== 16'h0 || sat !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 in reset actual %b %h %b expected 0 0000 0", light, digits, sat);
    end
    rst_n = 1'b1;
    expect_at(cyc + 1, "R9", 0, 0, 0);
    @(negedge clk);

    // Run 1: R3 delay, R5 realigned first tick, R2 stop freezes, R4 hold
    t = cyc;
    press(1);
    expect_at(t + 9,  "R3", 0, 0, 0);
    expect_at(t + 10, "R3", 1, 0, 0);
    expect_at(t + 14, "R5", 1, 0, 0);
    expect_at(t + 15, "R5", 1, 1, 0);
    expect_at(t + 20, "R4", 1, 2, 0);
    wait_to(t + 33);
    expect_at(t + 34, "R2", 0, 4, 0);
    expect_at(t + 45, "R2", 0, 4, 0);
    press(2);
    wait_to(t + 46);

    // Run 2: R7 clear, R6 carries, R8 saturation
    t = cyc;
    press(1);
    expect_at(t + 1, "R7", 0, 0, 0);
    expect_at(t + 10 + 45,  "R6", 1, 9, 0);
    expect_at(t + 10 + 50,  "R6", 1, 10, 0);
    expect_at(t + 10 + 495, "R6", 1, 99, 0);
    expect_at(t + 10 + 500, "R6", 1, 100, 0);
    expect_at(t + 10 + 4995, "R6", 1, 999, 0);
    expect_at(t + 10 + 5000, "R6", 1, 1000, 0);
    expect_at(t + 10 + 49994, "R8", 1, 9998, 0);
    expect_at(t + 10 + 49995, "R8", 1, 9999, 1);
    expect_at(t + 10 + 50100, "R8", 1, 9999, 1);
    wait_to(t + 10 + 50150);
    expect_at(cyc + 1, "R2", 0, 9999, 1);
    press(2);
    expect_at(cyc + 1, "R7", 0, 0, 0);
    press(1);
    wait_to(cyc + 4);
    expect_at(cyc + 1, "R1", 0, 0, 0);
    expect_at(cyc + 15, "R1", 0, 0, 0);
    press(0);
    wait_to(cyc + 20);

    // Run 3: reset while light on
    t = cyc;
    press(1);
    wait_to(t + 15);
    expect_at(t + 16, "R1", 0, 0, 0);
    press(0);
    wait_to(t + 25);

    // Run 4: reset and request together start nothing
    t = cyc;
    b_rst_n = 1'b0;
    press(1);
    expect_at(t + 12, "R1", 0, 0, 0);
    expect_at(t + 20, "R1", 0, 0, 0);
    wait_to(t + 22);

    // Run 5: stop before the light cancels the test
    t = cyc;
    press(1);
    wait_to(t + 5);
    press(2);
    expect_at(t + 15, "R10", 0, 0, 0);
    expect_at(t + 25, "R10", 0, 0, 0);
    wait_to(t + 27);

    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule